// File: doc/BRIEF.md
# Cascaded DMA Request Arbiter

This block decides which of eight DMA request lines may own the system bus. It is built from two identical four-channel arbitration controllers. The subordinate controller takes logical channels 0 to 3. The master controller takes logical channels 4 to 7 and is the only one that talks to the CPU, through a hold request output and a hold acknowledge input.

Logical channel 4 is the link between the two controllers and has no device pins. When link mode is enabled, the subordinate's hold request becomes the request of channel 4, and the master's grant on channel 4 becomes the subordinate's hold acknowledge. Devices on channels 5 to 7 request the master directly. A device on channels 0 to 3 reaches the CPU only through channel 4.

Software supplies a per-channel mask and the link-mode bit through a single write strobe. Address generation, transfer counts and bus strobes are handled elsewhere.

Top module: `dmaCascadeArb`

## Requirements
- R1: After reset, all eight mask bits are set and link mode is off. The hold request and all acknowledges are low.
- R2: Bit i of `cfgMask` masks logical channel i. A masked request is never acknowledged and does not raise the hold request. Clearing the mask bit lets the request proceed.
- R3: The master raises `cpuHoldReq` one clock after an unmasked request appears on channels 5 to 7.
- R4: A device acknowledge rises only after `cpuHoldAck` is high. For channels 5 to 7 it rises one clock after the master sees `cpuHoldAck` high while requesting.
- R5: Each controller grants its lowest-numbered pending unmasked channel. In the master, channel 4 (the subordinate) wins over channels 5 to 7.
- R6: A grant is held until the granted request drops, and a newly arriving lower-numbered request does not preempt it. When the granted request drops, the acknowledge falls on the next clock and that controller returns to idle.
- R7: When `cpuHoldAck` falls, every acknowledge is low after the next clock. The master goes idle, drops `cpuHoldReq`, and raises it again one clock later if a request is still pending.
- R8: Subordinate requests reach `cpuHoldReq` only through logical channel 4, and only while `cfgLink` is set and channel 4 is unmasked. `cpuHoldReq` rises two clocks after a subordinate request.
- R9: A subordinate acknowledge is high only while both the master's channel-4 grant and the subordinate's own grant are active. It rises two clocks after the master sees `cpuHoldAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for mask and link mode |
| cfgMask | input | 2*CH | Mask bit per logical channel, bit i is channel i |
| cfgLink | input | 1 | Link mode for logical channel 4 |
| reqSub | input | CH | Device requests, logical channels 0 to 3 |
| reqMain | input | CH-1 | Device requests, logical channels 5 to 7 (bit 0 is channel 5) |
| cpuHoldAck | input | 1 | Hold acknowledge from the CPU |
| cpuHoldReq | output | 1 | Hold request to the CPU |
| ackSub | output | CH | Device acknowledges, logical channels 0 to 3 |
| ackMain | output | CH-1 | Device acknowledges, logical channels 5 to 7 (bit 0 is channel 5) |

## Verification
The bench builds the block with the default of four channels per controller. With that setting every acknowledge and the hold request fit in one 8-bit observation word, which the scoreboard compares on every clock. This reaches the two-level latency through the link channel, the competition between the link channel and the direct channels, a hold-acknowledge withdrawal in the middle of a grant, and the effect of the link bit and of masking the link channel itself.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_WAIT,
    ARB_OWN
  } arbState_e;

  typedef struct packed {
    logic load;
    logic clear;
  } arbStrobe_t;
endpackage

// File: rtl/dmaArbPath.sv
module dmaArbPath
  import dmaArbPkg::*;
#(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CH-1:0] req,
  input  logic [CH-1:0] mask,
  input  arbStrobe_t    strb,
  output logic          anyPend,
  output logic          grantLive,
  output logic [CH-1:0] grantQ
);
  localparam logic [CH-1:0] ONE = {{(CH-1){1'b0}}, 1'b1};

  logic [CH-1:0] pend;
  logic [CH-1:0] pick;

  assign pend      = req & ~mask;
  assign pick      = pend & (~pend + ONE);
  assign anyPend   = |pend;
  assign grantLive = |(grantQ & pend);

  always_ff @(posedge clk) begin
    if (!rstN)           grantQ <= '0;
    else if (strb.clear) grantQ <= '0;
    else if (strb.load)  grantQ <= pick;
  end

  // R2: a fresh grant always lands on a channel that was pending and unmasked
  a_r2_grant_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grantQ) |-> |(grantQ & $past(pend)));

  // R6: an active grant never moves to another channel
  a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantQ) && (|$past(grantQ))) |-> (grantQ == $past(grantQ)));
endmodule

// File: rtl/dmaArbCtl.sv
module dmaArbCtl
  import dmaArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyPend,
  input  logic       grantLive,
  input  logic       holdAck,
  output arbStrobe_t strb,
  output logic       holdReq
);
  arbState_e st, nxt;

  always_comb begin
    nxt  = st;
    strb = '0;
    case (st)
      ARB_IDLE: if (anyPend) nxt = ARB_WAIT;
      ARB_WAIT: begin
        if (!anyPend) nxt = ARB_IDLE;
        else if (holdAck) begin
          nxt       = ARB_OWN;
          strb.load = 1'b1;
        end
      end
      ARB_OWN: begin
        if (!holdAck || !grantLive) begin
          nxt        = ARB_IDLE;
          strb.clear = 1'b1;
        end
      end
      default: nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ARB_IDLE;
    else       st <= nxt;
  end

  assign holdReq = (st != ARB_IDLE);
endmodule

// File: rtl/dmaCascadeArb.sv
module dmaCascadeArb
  import dmaArbPkg::*;
#(
  parameter int CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2*CH-1:0]   cfgMask,
  input  logic              cfgLink,
  input  logic [CH-1:0]     reqSub,
  input  logic [CH-2:0]     reqMain,
  input  logic              cpuHoldAck,
  output logic              cpuHoldReq,
  output logic [CH-1:0]     ackSub,
  output logic [CH-2:0]     ackMain
);
  localparam int NCTL = 2;
  localparam int TOT  = NCTL * CH;
  localparam int SUB  = 0;
  localparam int MST  = 1;

  logic [TOT-1:0]           maskQ;
  logic                     linkQ;
  logic [NCTL-1:0][CH-1:0]  ctlReq;
  logic [NCTL-1:0][CH-1:0]  ctlGrant;
  logic [NCTL-1:0]          ctlHoldReq;
  logic [NCTL-1:0]          ctlHoldAck;
  logic [NCTL-1:0]          ctlAnyPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
      linkQ <= 1'b0;
    end else if (cfgWe) begin
      maskQ <= cfgMask;
      linkQ <= cfgLink;
    end
  end

  // subordinate hold pair rides on master local channel 0 (logical 4)
  assign ctlReq[SUB]     = reqSub;
  assign ctlReq[MST]     = {reqMain, ctlHoldReq[SUB] & linkQ};
  assign ctlHoldAck[SUB] = ctlGrant[MST][0];
  assign ctlHoldAck[MST] = cpuHoldAck;

  for (genvar c = 0; c < NCTL; c++) begin : g_ctl
    arbStrobe_t strb;
    logic       grantLive;

    dmaArbPath #(.CH(CH)) u_path (
      .clk       (clk),
      .rstN      (rstN),
      .req       (ctlReq[c]),
      .mask      (maskQ[c*CH +: CH]),
      .strb      (strb),
      .anyPend   (ctlAnyPend[c]),
      .grantLive (grantLive),
      .grantQ    (ctlGrant[c])
    );

    dmaArbCtl u_ctl (
      .clk       (clk),
      .rstN      (rstN),
      .anyPend   (ctlAnyPend[c]),
      .grantLive (grantLive),
      .holdAck   (ctlHoldAck[c]),
      .strb      (strb),
      .holdReq   (ctlHoldReq[c])
    );

    // R4: a controller only takes a grant while its hold acknowledge is high
    a_r4_grant_after_ack: assert property (@(posedge clk) disable iff (!rstN)
      $rose(|ctlGrant[c]) |-> $past(ctlHoldAck[c]));
  end

  assign cpuHoldReq = ctlHoldReq[MST];
  assign ackMain    = ctlGrant[MST][CH-1:1];
  assign ackSub     = ctlGrant[SUB] & {CH{ctlGrant[MST][0]}};

  // R3: hold request only rises after the master saw a pending request
  a_r3_hold_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHoldReq) |-> $past(ctlAnyPend[MST]));

  // R7: withdrawal of hold acknowledge clears every device acknowledge
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHoldAck) |=> ((ackMain == '0) && (ackSub == '0)));

  // R8: the link channel is granted only while link mode was enabled
  a_r8_link_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlGrant[MST][0]) |-> $past(linkQ));
endmodule

// File: tb/sim_dmaCascadeArb.sv
`timescale 1ns/1ps
module sim_dmaCascadeArb;
  localparam int CH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgMask = '0;
  logic       cfgLink = 1'b0;
  logic [3:0] reqSub = '0;
  logic [2:0] reqMain = '0;
  logic       cpuHoldAck = 1'b0;
  logic       cpuHoldReq;
  logic [3:0] ackSub;
  logic [2:0] ackMain;

  int edgeCount = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  int         qAt[$];
  logic [7:0] qExp[$];
  string      qTag[$];

  dmaCascadeArb #(.CH(CH)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMask(cfgMask), .cfgLink(cfgLink),
    .reqSub(reqSub), .reqMain(reqMain), .cpuHoldAck(cpuHoldAck),
    .cpuHoldReq(cpuHoldReq), .ackSub(ackSub), .ackMain(ackMain)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] obs();
    return {cpuHoldReq, ackMain, ackSub};
  endfunction

  // monitor: compares the observation word against the scoreboard
  always @(posedge clk) begin
    #3;
    edgeCount++;
    if (qAt.size() > 0 && qAt[0] == edgeCount) begin
      logic [7:0] e;
      string t;
      e = qExp.pop_front();
      t = qTag.pop_front();
      void'(qAt.pop_front());
      nChecks++;
      if (obs() !== e) begin
        nFails++;
        $display("FAIL %s edge %0d: got %h expected %h", t, edgeCount, obs(), e);
      end
    end
  end

  // driver: inputs for the next edge and the word expected after it
  task automatic drv(input logic [3:0] rs, input logic [2:0] rm, input logic ha,
                     input logic [7:0] ex, input string tg);
    @(negedge clk);
    reqSub = rs;
    reqMain = rm;
    cpuHoldAck = ha;
    qAt.push_back(edgeCount + 1);
    qExp.push_back(ex);
    qTag.push_back(tg);
  endtask

  task automatic cfg(input logic [7:0] m, input logic l);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgMask = m;
    cfgLink = l;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (obs() !== 8'h00) begin
      nFails++;
      $display("FAIL R1 in reset: got %h expected 00", obs());
    end
    rstN = 1'b1;

    // R1, R2: everything masked straight out of reset
    drv(4'hF, 3'h7, 1'b1, 8'h00, "R1");
    drv(4'hF, 3'h7, 1'b1, 8'h00, "R2");
    drv(4'hF, 3'h7, 1'b1, 8'h00, "R2");
    drv(4'h0, 3'h0, 1'b0, 8'h00, "R1");

    cfg(8'h00, 1'b1);

    // R3, R4, R6: channel 6 direct
    drv(4'h0, 3'b010, 1'b0, 8'h80, "R3");
    drv(4'h0, 3'b010, 1'b0, 8'h80, "R4");
    drv(4'h0, 3'b010, 1'b1, 8'hA0, "R4");
    drv(4'h0, 3'b010, 1'b1, 8'hA0, "R6");
    drv(4'h0, 3'b000, 1'b1, 8'h00, "R6");
    drv(4'h0, 3'b000, 1'b0, 8'h00, "R6");

    // R8, R9: channel 2 through the link channel
    drv(4'b0100, 3'h0, 1'b0, 8'h00, "R8");
    drv(4'b0100, 3'h0, 1'b0, 8'h80, "R8");
    drv(4'b0100, 3'h0, 1'b1, 8'h80, "R9");
    drv(4'b0100, 3'h0, 1'b1, 8'h84, "R9");
    drv(4'b0000, 3'h0, 1'b1, 8'h80, "R6");
    drv(4'b0000, 3'h0, 1'b1, 8'h00, "R6");
    drv(4'b0000, 3'h0, 1'b0, 8'h00, "R6");

    // R7: hold acknowledge withdrawn mid-grant on channel 5
    drv(4'h0, 3'b001, 1'b0, 8'h80, "R3");
    drv(4'h0, 3'b001, 1'b1, 8'h90, "R4");
    drv(4'h0, 3'b001, 1'b0, 8'h00, "R7");
    drv(4'h0, 3'b001, 1'b0, 8'h80, "R7");
    drv(4'h0, 3'b000, 1'b0, 8'h00, "R7");

    // R5, R6: priority in both controllers, no preemption
    drv(4'b1010, 3'b010, 1'b1, 8'h80, "R5");
    drv(4'b1010, 3'b010, 1'b1, 8'h80, "R5");
    drv(4'b1010, 3'b010, 1'b1, 8'h82, "R5");
    drv(4'b1011, 3'b010, 1'b1, 8'h82, "R6");
    drv(4'b1001, 3'b010, 1'b1, 8'h80, "R6");
    drv(4'b1001, 3'b010, 1'b1, 8'h00, "R6");
    drv(4'b1001, 3'b010, 1'b1, 8'h80, "R5");
    drv(4'b1001, 3'b010, 1'b1, 8'h80, "R5");
    drv(4'b1001, 3'b010, 1'b1, 8'h81, "R5");
    drv(4'b0000, 3'b000, 1'b0, 8'h00, "R7");
    drv(4'b0000, 3'b000, 1'b0, 8'h00, "R7");

    // R8: link mode off blocks the subordinate
    cfg(8'h00, 1'b0);
    drv(4'b0001, 3'h0, 1'b1, 8'h00, "R8");
    drv(4'b0001, 3'h0, 1'b1, 8'h00, "R8");
    drv(4'b0001, 3'h0, 1'b1, 8'h00, "R8");
    drv(4'b0000, 3'h0, 1'b0, 8'h00, "R8");

    // R2: link channel 4 and channel 7 masked
    cfg(8'h90, 1'b1);
    drv(4'b0001, 3'b100, 1'b1, 8'h00, "R2");
    drv(4'b0001, 3'b100, 1'b1, 8'h00, "R2");
    drv(4'b0001, 3'b100, 1'b1, 8'h00, "R2");
    drv(4'b0000, 3'b000, 1'b0, 8'h00, "R2");

    // R2: unmasking channel 7 lets it through
    cfg(8'h00, 1'b1);
    drv(4'h0, 3'b100, 1'b1, 8'h80, "R2");
    drv(4'h0, 3'b100, 1'b1, 8'hC0, "R2");
    drv(4'h0, 3'b000, 1'b0, 8'h00, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule